// File: doc/BRIEF.md
# Active-Rule Fuzzy Inference Controller

This block is a two-input, one-output fuzzy controller of the zero-order Takagi-Sugeno kind. Each clock cycle it can take a pair of 8-bit crisp inputs. It grades each input against a programmable bank of trapezoidal membership functions and combines the surviving grades through a table of constant rule outputs. It then delivers a 12-bit crisp result, which is the weighted mean of the consequents of the rules that fire.

The membership functions of each input are split by index parity into an even bank and an odd bank. Neighbouring functions are meant to overlap so that at most one function of each bank is non-zero at any input value. Each input therefore contributes at most two grades, and the block evaluates exactly four candidate rules per input pair, whatever the size of the rule table. The four rules are even/even, even/odd, odd/even and odd/odd. Breakpoints, edge slopes and consequents are loaded through a plain write port while the pipeline is empty. A result with no firing rule is flagged invalid rather than divided by zero.

Top module: `fz_ctrl`

## Requirements
- R1: Each membership function has breakpoints a, b, c, d and two slopes, a rise slope and a fall slope. Its degree for input x is defined piecewise:
  - 0 when x < a or x > d;
  - min(255, (x-a)*rise) when a ≤ x < b;
  - 255 when b ≤ x ≤ c;
  - min(255, (d-x)*fall) when c < x ≤ d.
- R2: For each input, the block selects the lowest-indexed even function with a non-zero degree and the lowest-indexed odd function with a non-zero degree. A bank with none contributes degree 0. The four candidate rules pair the two picks of input 0 (index i) with the two picks of input 1 (index j). Each rule uses consequent number i*NMF + j.
- R3: The weight of a rule is the smaller of its two antecedent degrees.
- R4: A valid result equals floor(sum(weight*consequent) / sum(weight)) over the four candidate rules, and out_invalid is 0.
- R5: When the weight sum is zero, out_data is 12'h000 and out_invalid is 1.
- R6: A pair presented with in_valid at a rising edge produces out_valid exactly three rising edges later. Pairs may be presented on consecutive cycles, and results appear in order.
- R7: The address map has two regions:
  - A write with wr_addr[7]=0 and wr_addr < NMF*NMF loads consequent wr_addr from wr_data[11:0].
  - A write with wr_addr[7]=1 loads an 8-bit value from wr_data[7:0] into one field of one function. wr_addr[6] selects the input and wr_addr[5:3] the function. wr_addr[2:0] selects the field: 0 a, 1 b, 2 c, 3 d, 4 rise, 5 fall.
  - After reset all parameters are zero.
- R8: A write is dropped unless the pipeline is idle. Idle means in_valid is low and neither of the first two stages holds a pair.
- R9: out_data and out_invalid keep their values on cycles when out_valid is low. After reset out_valid, out_data and out_invalid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pair present this cycle |
| in_x0 | input | 8 | Crisp input 0 |
| in_x1 | input | 8 | Crisp input 1 |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | 8 | Parameter write address |
| wr_data | input | 12 | Parameter write data |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 12 | Crisp weighted-mean result |
| out_invalid | output | 1 | No rule fired for this result |

## Verification
The bench builds the block with the default NMF = 7, which fills the whole 49-entry rule table. The selection then spans functions 0 to 6 in both parity banks, so the last odd function and the last even function both come into reach. With all parameters still at their reset value of zero, every function grades 255 at x = 0, which exercises the lowest-index choice among many non-zero candidates. The same zero parameters leave no rule firing at any other input, which reaches the invalid path. Once the banks are configured with overlapping trapezoids, swept and back-to-back inputs cover the rising, flat and falling edges of every function, together with writes attempted while pairs are still in flight.

// File: rtl/fz_pkg.sv
package fz_pkg;
  parameter int X_W      = 8;
  parameter int DEG_W    = 8;
  parameter int OUT_W    = 12;
  parameter int ADDR_W   = 8;
  parameter int N_FIELD  = 6;
  parameter int MF_IDX_W = 3;
  localparam logic [DEG_W-1:0] DEG_FULL = '1;

  typedef enum logic [2:0] {
    FLD_A = 3'd0, FLD_B = 3'd1, FLD_C = 3'd2, FLD_D = 3'd3,
    FLD_RISE = 3'd4, FLD_FALL = 3'd5
  } fz_field_e;

  typedef struct packed {
    logic [MF_IDX_W-1:0] idx;
    logic [DEG_W-1:0]    deg;
  } fz_pick_t;
endpackage

// File: rtl/fz_trap.sv
module fz_trap
  import fz_pkg::*;
(
  input  logic [X_W-1:0]                x,
  input  logic [N_FIELD-1:0][X_W-1:0]   prm,
  output logic [DEG_W-1:0]              deg
);
  localparam int PROD_W = 2 * X_W;

  logic [X_W-1:0]    pa, pb, pc, pd, rise, fall;
  logic [PROD_W-1:0] ramp;

  assign pa   = prm[FLD_A];
  assign pb   = prm[FLD_B];
  assign pc   = prm[FLD_C];
  assign pd   = prm[FLD_D];
  assign rise = prm[FLD_RISE];
  assign fall = prm[FLD_FALL];

  always_comb begin
    ramp = '0;
    deg  = '0;
    if (x < pa) begin
      deg = '0;
    end else if (x < pb) begin
      ramp = PROD_W'(x - pa) * PROD_W'(rise);
      deg  = (ramp > PROD_W'(DEG_FULL)) ? DEG_FULL : ramp[DEG_W-1:0];
    end else if (x <= pc) begin
      deg = DEG_FULL;
    end else if (x <= pd) begin
      ramp = PROD_W'(pd - x) * PROD_W'(fall);
      deg  = (ramp > PROD_W'(DEG_FULL)) ? DEG_FULL : ramp[DEG_W-1:0];
    end
  end
endmodule

// File: rtl/fz_fuzzifier.sv
module fz_fuzzifier
  import fz_pkg::*;
#(
  parameter int NMF = 7
) (
  input  logic [X_W-1:0]                          x,
  input  logic [NMF-1:0][N_FIELD-1:0][X_W-1:0]    prm,
  output fz_pick_t                                even_p,
  output fz_pick_t                                odd_p
);
  logic [NMF-1:0][DEG_W-1:0] deg;

  for (genvar k = 0; k < NMF; k++) begin : g_mf
    fz_trap u_trap (.x(x), .prm(prm[k]), .deg(deg[k]));
  end

  // walk from the top down so the lowest non-zero index of each bank wins
  always_comb begin
    even_p = '0;
    odd_p  = '0;
    for (int k = NMF - 1; k >= 0; k--) begin
      if (deg[k] != '0) begin
        if (k % 2 == 0) begin
          even_p.idx = MF_IDX_W'(k);
          even_p.deg = deg[k];
        end else begin
          odd_p.idx = MF_IDX_W'(k);
          odd_p.deg = deg[k];
        end
      end
    end
  end
endmodule

// File: rtl/fz_param_regs.sv
module fz_param_regs
  import fz_pkg::*;
#(
  parameter int NMF = 7,
  localparam int NRULE  = NMF * NMF,
  localparam int CIDX_W = $clog2(NRULE)
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         wr_en,
  input  logic                                         idle,
  input  logic [ADDR_W-1:0]                            wr_addr,
  input  logic [OUT_W-1:0]                             wr_data,
  output logic [1:0][NMF-1:0][N_FIELD-1:0][X_W-1:0]    bp,
  output logic [NRULE-1:0][OUT_W-1:0]                  cons
);
  logic [1:0][NMF-1:0][N_FIELD-1:0][X_W-1:0] bp_d, bp_q;
  logic [NRULE-1:0][OUT_W-1:0]               cons_d, cons_q;
  logic                                      take;
  logic                                      sel_in;
  logic [MF_IDX_W-1:0]                       sel_mf;
  logic [2:0]                                sel_fld;

  assign take    = wr_en && idle;
  assign sel_in  = wr_addr[6];
  assign sel_mf  = wr_addr[5:3];
  assign sel_fld = wr_addr[2:0];

  always_comb begin
    bp_d   = bp_q;
    cons_d = cons_q;
    if (take) begin
      if (wr_addr[7]) begin
        if (int'(sel_mf) < NMF && int'(sel_fld) < N_FIELD)
          bp_d[sel_in][sel_mf][sel_fld] = wr_data[X_W-1:0];
      end else if (int'(wr_addr) < NRULE) begin
        cons_d[wr_addr[CIDX_W-1:0]] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= '0;
      cons_q <= '0;
    end else if (take) begin
      bp_q   <= bp_d;
      cons_q <= cons_d;
    end
  end

  assign bp   = bp_q;
  assign cons = cons_q;
endmodule

// File: rtl/fz_ctrl.sv
module fz_ctrl
  import fz_pkg::*;
#(
  parameter int NMF = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              in_valid,
  input  logic [X_W-1:0]    in_x0,
  input  logic [X_W-1:0]    in_x1,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OUT_W-1:0]  wr_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_invalid
);
  localparam int NRULE  = NMF * NMF;
  localparam int CIDX_W = $clog2(NRULE);
  localparam int WSUM_W = DEG_W + 2;
  localparam int NUM_W  = DEG_W + OUT_W + 2;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic v1_q, v2_q, v3_q;
  logic idle;
  assign idle = !in_valid && !v1_q && !v2_q;

  logic [1:0][NMF-1:0][N_FIELD-1:0][X_W-1:0] bp_w;
  logic [NRULE-1:0][OUT_W-1:0]               cons_w;

  fz_param_regs #(.NMF(NMF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idle(idle),
    .wr_addr(wr_addr), .wr_data(wr_data), .bp(bp_w), .cons(cons_w)
  );

  // stage 1: fuzzify, pick [0]=even in0 [1]=odd in0 [2]=even in1 [3]=odd in1
  logic [1:0][X_W-1:0] xin;
  fz_pick_t [3:0]      p1_d, p1_q;
  assign xin = {in_x1, in_x0};

  for (genvar i = 0; i < 2; i++) begin : g_in
    fz_fuzzifier #(.NMF(NMF)) u_fuzz (
      .x(xin[i]), .prm(bp_w[i]),
      .even_p(p1_d[2*i]), .odd_p(p1_d[2*i+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        p1_q <= '0;
    else if (in_valid) p1_q <= p1_d;
  end

  // stage 2: four candidate rules, weighted sums
  logic [3:0][DEG_W-1:0]  w;
  logic [3:0][CIDX_W-1:0] cidx;
  logic [3:0][NUM_W-1:0]  prod;
  logic [NUM_W-1:0]       num_d, num_q;
  logic [WSUM_W-1:0]      den_d, den_q;

  for (genvar r = 0; r < 4; r++) begin : g_rule
    fz_pick_t pa, pb;
    assign pa      = p1_q[r / 2];
    assign pb      = p1_q[2 + (r % 2)];
    assign w[r]    = (pa.deg < pb.deg) ? pa.deg : pb.deg;
    assign cidx[r] = CIDX_W'(pa.idx) * CIDX_W'(NMF) + CIDX_W'(pb.idx);
    assign prod[r] = NUM_W'(w[r]) * NUM_W'(cons_w[cidx[r]]);
  end

  always_comb begin
    num_d = '0;
    den_d = '0;
    for (int r = 0; r < 4; r++) begin
      num_d = num_d + prod[r];
      den_d = den_d + WSUM_W'(w[r]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
    end else if (v1_q) begin
      num_q <= num_d;
      den_q <= den_d;
    end
  end

  // stage 3: divide, or flag an empty rule set
  logic [NUM_W-1:0] quo;
  logic [OUT_W-1:0] od_d, od_q;
  logic             oi_d, oi_q;

  always_comb begin
    quo  = '0;
    od_d = '0;
    oi_d = 1'b1;
    if (den_q != '0) begin
      quo  = num_q / NUM_W'(den_q);
      od_d = quo[OUT_W-1:0];
      oi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
      oi_q <= 1'b0;
    end else if (v2_q) begin
      od_q <= od_d;
      oi_q <= oi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  assign out_valid   = v3_q;
  assign out_data    = od_q;
  assign out_invalid = oi_q;
endmodule

// File: rtl/fz_ctrl_chk.sv
module fz_ctrl_chk
  import fz_pkg::*;
#(
  parameter int NMF = 7,
  localparam int NRULE = NMF * NMF
) (
  input logic                                       clk,
  input logic                                       rst_n,
  input logic                                       in_valid,
  input logic                                       wr_en,
  input logic                                       v1_q,
  input logic                                       v2_q,
  input logic                                       out_valid,
  input logic [OUT_W-1:0]                           out_data,
  input logic                                       out_invalid,
  input logic [1:0][NMF-1:0][N_FIELD-1:0][X_W-1:0]  bp_w,
  input logic [NRULE-1:0][OUT_W-1:0]                cons_w
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R6
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_data == '0));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_invalid)));

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid || v1_q || v2_q) |=> ($stable(cons_w) && $stable(bp_w)));

  // R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cons_w) && $stable(bp_w)));
endmodule

bind fz_ctrl fz_ctrl_chk #(.NMF(NMF)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_en(wr_en),
  .v1_q(v1_q), .v2_q(v2_q), .out_valid(out_valid), .out_data(out_data),
  .out_invalid(out_invalid), .bp_w(bp_w), .cons_w(cons_w)
);

// File: tb/fz_ctrl_bench.sv
`timescale 1ns/1ps
module fz_ctrl_bench;
  localparam int NMF = 7;
  localparam int NR  = NMF * NMF;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        in_valid;
  logic [7:0]  in_x0, in_x1;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [11:0] wr_data;
  logic        out_valid;
  logic [11:0] out_data;
  logic        out_invalid;

  fz_ctrl #(.NMF(NMF)) u_fz_ctrl (
    .clk(clk), .rst_ni(rst_ni), .in_valid(in_valid), .in_x0(in_x0),
    .in_x1(in_x1), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data), .out_invalid(out_invalid)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // model state, updated only by accepted writes
  int mprm [2][NMF][6];
  int mcons[NR];

  typedef struct {
    int    data;
    bit    inv;
    int    issued;
    string tag;
  } exp_t;
  exp_t sb[$];

  function automatic int trap(int x, int a, int b, int c, int d, int su, int sd);
    int t;
    if (x < a) return 0;
    if (x < b) begin t = (x - a) * su; return (t > 255) ? 255 : t; end
    if (x <= c) return 255;
    if (x <= d) begin t = (d - x) * sd; return (t > 255) ? 255 : t; end
    return 0;
  endfunction

  task automatic pick(input int inp, input int x, output int ei, output int ed,
                      output int oi, output int od);
    ei = 0; ed = 0; oi = 0; od = 0;
    for (int k = NMF - 1; k >= 0; k--) begin
      int g;
      g = trap(x, mprm[inp][k][0], mprm[inp][k][1], mprm[inp][k][2],
               mprm[inp][k][3], mprm[inp][k][4], mprm[inp][k][5]);
      if (g != 0) begin
        if (k % 2 == 0) begin ei = k; ed = g; end
        else begin oi = k; od = g; end
      end
    end
  endtask

  task automatic model(input int x0, input int x1, output int res, output bit inv);
    int ix[2], dx[2], iy[2], dy[2];
    int num, den;
    pick(0, x0, ix[0], dx[0], ix[1], dx[1]);
    pick(1, x1, iy[0], dy[0], iy[1], dy[1]);
    num = 0; den = 0;
    for (int p = 0; p < 2; p++)
      for (int q = 0; q < 2; q++) begin
        int wgt;
        wgt = (dx[p] < dy[q]) ? dx[p] : dy[q];
        num += wgt * mcons[ix[p] * NMF + iy[q]];
        den += wgt;
      end
    if (den == 0) begin res = 0; inv = 1; end
    else begin res = num / den; inv = 0; end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one input pair, optional simultaneous write that must be dropped
  task automatic send(input int x0, input int x1, input string tag);
    exp_t e;
    int r; bit iv;
    model(x0, x1, r, iv);
    e.data = r; e.inv = iv; e.issued = cyc; e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1; in_x0 = 8'(x0); in_x1 = 8'(x1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wr(input int addr, input int data, input bit accepted);
    wr_en = 1'b1; wr_addr = 8'(addr); wr_data = 12'(data);
    if (accepted) begin
      if (addr >= 128) mprm[(addr >> 6) & 1][(addr >> 3) & 7][addr & 7] = data & 255;
      else if (addr < NR) mcons[addr] = data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_ni && out_valid) begin
      if (sb.size() == 0) begin
        check("R6 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " R4 data"}, int'(out_data), e.data);
        check({e.tag, " R5 invalid flag"}, int'(out_invalid), int'(e.inv));
        check({e.tag, " R6 latency"}, cyc - e.issued, 3);
      end
    end
  end

  function automatic void summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int lf;
    int old0;
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < NMF; k++)
        for (int f = 0; f < 6; f++) mprm[i][k][f] = 0;
    for (int r = 0; r < NR; r++) mcons[r] = 0;
    rst_ni = 1'b0; in_valid = 1'b0; in_x0 = '0; in_x1 = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check("R9 reset out_valid", int'(out_valid), 0);
    check("R9 reset out_data", int'(out_data), 0);
    check("R9 reset out_invalid", int'(out_invalid), 0);

    // R7 zero parameters: x=5 grades nothing -> R5 empty rule set
    send(5, 5, "R5 R7 zero params");
    wait_idle(4);
    check("R9 hold invalid after result", int'(out_invalid), 1);
    send(0, 0, "R2 zero params all full");
    wait_idle(4);

    // load consequents, then every function grades 255 at 0: R2 lowest-index pick
    for (int r = 0; r < NR; r++) wr(r, (r * 83 + 17) % 4096, 1);
    send(0, 0, "R2 lowest index among equals");
    send(5, 5, "R5 nothing fires");
    wait_idle(4);

    // overlapping trapezoids on both inputs, R1 shapes
    for (int i = 0; i < 2; i++)
      for (int k = 0; k < NMF; k++) begin
        int a, b, c, d;
        a = 40 * k - 40; b = 40 * k - 10; c = 40 * k + 10; d = 40 * k + 40;
        if (a < 0) a = 0; if (b < 0) b = 0; if (d > 255) d = 255;
        wr(128 + i * 64 + k * 8 + 0, a, 1);
        wr(128 + i * 64 + k * 8 + 1, b, 1);
        wr(128 + i * 64 + k * 8 + 2, c, 1);
        wr(128 + i * 64 + k * 8 + 3, d, 1);
        wr(128 + i * 64 + k * 8 + 4, (i == 0) ? 8 : 6, 1);
        wr(128 + i * 64 + k * 8 + 5, (i == 0) ? 8 : 9, 1);
      end
    // out-of-map writes must change nothing
    wr(60, 4095, 1);
    wr(128 + 7 * 8, 99, 1);
    wr(128 + 2 * 8 + 6, 99, 1);

    // directed points on edges and plateaus (R1 R3 R4)
    send(0, 0, "R1 R3 corner");
    send(20, 20, "R1 R3 rising");
    send(35, 100, "R1 R3 mixed");
    send(255, 255, "R1 top end");
    send(128, 3, "R1 R3 falling");
    send(200, 200, "R2 bank boundary");
    wait_idle(4);

    // back-to-back stream (R6)
    lf = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      lf = ((lf >> 1) | (((lf ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
      send(lf & 255, (lf >> 8) & 255, "R6 stream");
    end
    // gapped pattern
    for (int n = 0; n < 20; n++) begin
      send((n * 13) % 256, 255 - (n * 11) % 256, "R4 gapped");
      wait_idle(n % 3);
    end
    wait_idle(4);

    // R8 writes while busy are dropped
    old0 = mcons[0];
    wr_en = 1'b1; wr_addr = 8'd0; wr_data = 12'd3000;
    send(0, 0, "R8 issue with write");
    wr_en = 1'b0;
    wr(0, 3001, 0);
    wr(128, 200, 0);
    wait_idle(4);
    send(0, 0, "R8 consequent unchanged");
    wait_idle(4);
    check("R8 model kept", mcons[0], old0);

    // R7 idle write takes effect
    wr(0, 3002, 1);
    send(0, 0, "R7 consequent updated");
    wait_idle(6);

    check("R6 all results delivered", sb.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule